// File: doc/BRIEF.md
# EEPROM access and burst loader

This block lets a host reach a byte-wide EEPROM in two ways. In the first, the host sets a request bit in a command register. The block then moves one byte between the EEPROM and its own data register, at the address held in its address register. In the second, the host starts a burst load. The block reads a stream of records from the EEPROM and writes the bytes they carry into a 24-bit internal memory space.

Each record begins with a 16-bit target address, high byte first. An 8-bit byte count follows, then that many data bytes. A record with a count of zero ends the burst. The memory address of each data byte is built from two parts. The top nine bits come from a base register. The low fifteen bits come from the record address, which advances by one per byte. The top bit of the record address is discarded.

The EEPROM side is a request/ready handshake. The memory side is a valid/ready stream. The block holds a byte on that stream until the sink accepts it. It issues no further EEPROM read while a byte is waiting, so a slow sink stalls the whole burst and no data is lost. The host side is a plain register port: a write strobe, a register select, write data, and combinational read data.

Top module: `eeprom_loader`

## Requirements
- R1: Writing the command register (select 0) with bit 1 set reads the EEPROM byte at the address register (select 1) into the data register (select 2). Bit 1 then reads back 0 once the data is valid.
- R2: Writing the command register with bit 0 set writes the data register's byte to the EEPROM at the address register. Bit 0 then returns to 0 by itself.
- R3: If bits 0 and 1 are both set in one command write, only the read is performed and both bits clear.
- R4: Command bit 2 reads 1 while a single access or a burst is pending or running. Host writes to any register during that time are ignored.
- R5: Writing 1 to bit 0 of the load register (select 4) starts a burst. The bit reads 0 again once the burst has ended.
- R6: A burst started after reset with no earlier EEPROM access reads its first record from EEPROM address 0.
- R7: Any other burst starts at the EEPROM address one past the last address accessed, whether that access was a single access or part of a burst.
- R8: Records are parsed as address high byte, address low byte, count, then count data bytes. A count of 0 ends the burst without any memory write.
- R9: Each data byte goes to memory address {base register (select 3) bits [8:0], record address bits [14:0]}. The record address increments per byte and wraps within 15 bits.
- R10: ee_req stays high with a stable address, direction and write byte until ee_ready. Exactly one transfer completes per request.
- R11: mem_valid stays high with a stable mem_addr and mem_data until mem_ready is high. No EEPROM request is made while a byte waits.
- R12: After reset all registers read 0, ee_req is 0 and mem_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select (0 command, 1 address, 2 data, 3 base, 4 load) |
| host_wdata | input | HOST_W | Register write data |
| host_rdata | output | HOST_W | Read data of the selected register |
| ee_req | output | 1 | EEPROM transfer request |
| ee_rd_nwr | output | 1 | 1 = read, 0 = write |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ready | input | 1 | Transfer completes in this cycle |
| ee_rdata | input | 8 | Read byte, valid with ee_ready |
| mem_valid | output | 1 | Memory write byte offered |
| mem_ready | input | 1 | Sink accepts the byte |
| mem_addr | output | BASE_W+15 | Target memory address |
| mem_data | output | 8 | Byte to write to memory |

## Verification
The bench builds the block with its default parameters: a 16-bit EEPROM address, a 9-bit base and a 32-bit host port. With those values the 15-bit wrap of the record address is reachable from a single record starting at 0x7FFF. Two distinct base values show that the upper nine memory address bits follow the register. A sink that accepts only one cycle in three keeps the memory stream stalled for most of each burst. An EEPROM model with a two-cycle latency keeps requests pending across several edges.

// File: rtl/eld_pkg.sv
package eld_pkg;
  typedef enum logic [2:0] {
    SEL_CMD   = 3'd0,
    SEL_EEADR = 3'd1,
    SEL_EEDAT = 3'd2,
    SEL_MBASE = 3'd3,
    SEL_LOAD  = 3'd4
  } sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SGL, ST_AHI, ST_ALO, ST_LEN, ST_DAT, ST_MEM
  } st_e;

  localparam int CMD_WR_BIT   = 0;
  localparam int CMD_RD_BIT   = 1;
  localparam int CMD_BUSY_BIT = 2;
endpackage

// File: rtl/eld_regs.sv
module eld_regs
  import eld_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int EE_AW  = 16,
  parameter int BYTE_W = 8,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              fsm_active,
  input  logic              clr_single,
  input  logic              load_data,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              clr_burst,
  output logic              rq_rd,
  output logic              rq_wr,
  output logic              burst_q,
  output logic [EE_AW-1:0]  addr_q,
  output logic [BYTE_W-1:0] data_q,
  output logic [BASE_W-1:0] base_q,
  output logic              busy
);

  assign busy = rq_rd | rq_wr | burst_q | fsm_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_rd   <= 1'b0;
      rq_wr   <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      base_q  <= '0;
    end else begin
      if (host_wr && !busy) begin
        case (sel_e'(host_sel))
          SEL_CMD: begin
            rq_wr <= host_wdata[CMD_WR_BIT];
            rq_rd <= host_wdata[CMD_RD_BIT];
          end
          SEL_EEADR: addr_q  <= host_wdata[EE_AW-1:0];
          SEL_EEDAT: data_q  <= host_wdata[BYTE_W-1:0];
          SEL_MBASE: base_q  <= host_wdata[BASE_W-1:0];
          SEL_LOAD:  burst_q <= host_wdata[0];
          default: ;
        endcase
      end
      if (clr_single) begin
        rq_rd <= 1'b0;
        rq_wr <= 1'b0;
      end
      if (load_data) data_q <= load_byte;
      if (clr_burst) burst_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (sel_e'(host_sel))
      SEL_CMD: begin
        host_rdata[CMD_WR_BIT]   = rq_wr;
        host_rdata[CMD_RD_BIT]   = rq_rd;
        host_rdata[CMD_BUSY_BIT] = busy;
      end
      SEL_EEADR: host_rdata[EE_AW-1:0]  = addr_q;
      SEL_EEDAT: host_rdata[BYTE_W-1:0] = data_q;
      SEL_MBASE: host_rdata[BASE_W-1:0] = base_q;
      SEL_LOAD:  host_rdata[0]          = burst_q;
      default: ;
    endcase
  end

  AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> ($stable(addr_q) && $stable(base_q))) else $error("locked regs changed"); // R4
  AST_CLR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    clr_single |-> (rq_rd || rq_wr)) else $error("single done without request"); // R1
endmodule

// File: rtl/eld_eeport.sv
module eld_eeport #(
  parameter int EE_AW  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rd,
  input  logic [EE_AW-1:0]  go_addr,
  input  logic [BYTE_W-1:0] go_wdata,
  output logic              ee_req,
  output logic              ee_rd_nwr,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [BYTE_W-1:0] ee_wdata,
  input  logic              ee_ready,
  output logic              fin
);

  assign fin = ee_req & ee_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ee_req    <= 1'b0;
      ee_rd_nwr <= 1'b1;
      ee_addr   <= '0;
      ee_wdata  <= '0;
    end else if (go) begin
      ee_req    <= 1'b1;
      ee_rd_nwr <= go_rd;
      ee_addr   <= go_addr;
      ee_wdata  <= go_wdata;
    end else if (fin) begin
      ee_req <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ready) |=> (ee_req && $stable(ee_addr) && $stable(ee_rd_nwr) && $stable(ee_wdata)))
    else $error("request dropped or changed"); // R10
  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!ee_req || ee_ready)) else $error("new request over pending one"); // R10
endmodule

// File: rtl/eld_ctrl.sv
module eld_ctrl
  import eld_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int BYTE_W = 8,
  parameter int BASE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rq_rd,
  input  logic                      rq_wr,
  input  logic                      burst_q,
  input  logic [EE_AW-1:0]          addr_q,
  input  logic [BYTE_W-1:0]         data_q,
  input  logic [BASE_W-1:0]         base_q,
  input  logic                      fin,
  input  logic [BYTE_W-1:0]         fin_data,
  input  logic                      cur_rd,
  input  logic                      port_req,
  output logic                      go,
  output logic                      go_rd,
  output logic [EE_AW-1:0]          go_addr,
  output logic [BYTE_W-1:0]         go_wdata,
  output logic                      clr_single,
  output logic                      load_data,
  output logic                      clr_burst,
  output logic                      fsm_active,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic [BASE_W+2*BYTE_W-2:0] mem_addr,
  output logic [BYTE_W-1:0]         mem_data
);
  localparam int TGT_W = 2 * BYTE_W;
  localparam int LOW_W = TGT_W - 1;

  st_e               st, nxt;
  logic [EE_AW-1:0]  ptr_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [BYTE_W-1:0] cnt_q;
  logic [BYTE_W-1:0] mbuf_q;

  assign fsm_active = (st != ST_IDLE);
  assign mem_valid  = (st == ST_MEM);
  assign mem_addr   = {base_q, tgt_q[LOW_W-1:0]};
  assign mem_data   = mbuf_q;

  always_comb begin
    nxt        = st;
    go         = 1'b0;
    go_rd      = 1'b1;
    go_addr    = ptr_q;
    go_wdata   = data_q;
    clr_single = 1'b0;
    load_data  = 1'b0;
    clr_burst  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (rq_rd || rq_wr) begin
          go      = 1'b1;
          go_rd   = rq_rd;
          go_addr = addr_q;
          nxt     = ST_SGL;
        end else if (burst_q) begin
          go  = 1'b1;
          nxt = ST_AHI;
        end
      end
      ST_SGL: begin
        if (fin) begin
          clr_single = 1'b1;
          load_data  = cur_rd;
          nxt        = ST_IDLE;
        end
      end
      ST_AHI: begin
        if (fin) begin
          go  = 1'b1;
          nxt = ST_ALO;
        end
      end
      ST_ALO: begin
        if (fin) begin
          go  = 1'b1;
          nxt = ST_LEN;
        end
      end
      ST_LEN: begin
        if (fin) begin
          if (fin_data == '0) begin
            clr_burst = 1'b1;
            nxt       = ST_IDLE;
          end else begin
            go  = 1'b1;
            nxt = ST_DAT;
          end
        end
      end
      ST_DAT: begin
        if (fin) nxt = ST_MEM;
      end
      ST_MEM: begin
        if (mem_ready) begin
          go  = 1'b1;
          nxt = (cnt_q == BYTE_W'(1)) ? ST_AHI : ST_DAT;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ptr_q  <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
      mbuf_q <= '0;
    end else begin
      st <= nxt;
      if (go) ptr_q <= go_addr + EE_AW'(1);
      case (st)
        ST_AHI: if (fin) tgt_q[TGT_W-1 -: BYTE_W] <= fin_data;
        ST_ALO: if (fin) tgt_q[BYTE_W-1:0] <= fin_data;
        ST_LEN: if (fin) cnt_q <= fin_data;
        ST_DAT: if (fin) mbuf_q <= fin_data;
        ST_MEM: if (mem_ready) begin
          tgt_q <= tgt_q + TGT_W'(1);
          cnt_q <= cnt_q - BYTE_W'(1);
        end
        default: ;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)))
    else $error("memory byte dropped or changed"); // R11
  AST_NO_EE_WHILE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !port_req) else $error("EEPROM busy while byte waits"); // R11
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (cnt_q != '0)) else $error("data byte after zero count"); // R8
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader #(
  parameter int HOST_W = 32,
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [2:0]           host_sel,
  input  logic [HOST_W-1:0]    host_wdata,
  output logic [HOST_W-1:0]    host_rdata,
  output logic                 ee_req,
  output logic                 ee_rd_nwr,
  output logic [EE_AW-1:0]     ee_addr,
  output logic [7:0]           ee_wdata,
  input  logic                 ee_ready,
  input  logic [7:0]           ee_rdata,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [BASE_W+14:0]   mem_addr,
  output logic [7:0]           mem_data
);
  localparam int BYTE_W = 8;

  logic              rq_rd, rq_wr, burst_q, busy;
  logic [EE_AW-1:0]  addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [BASE_W-1:0] base_q;
  logic              fsm_active, clr_single, load_data, clr_burst;
  logic              go, go_rd, fin;
  logic [EE_AW-1:0]  go_addr;
  logic [BYTE_W-1:0] go_wdata;

  eld_regs #(.HOST_W(HOST_W), .EE_AW(EE_AW), .BYTE_W(BYTE_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fsm_active(fsm_active),
    .clr_single(clr_single), .load_data(load_data), .load_byte(ee_rdata),
    .clr_burst(clr_burst), .rq_rd(rq_rd), .rq_wr(rq_wr), .burst_q(burst_q),
    .addr_q(addr_q), .data_q(data_q), .base_q(base_q), .busy(busy)
  );

  eld_eeport #(.EE_AW(EE_AW), .BYTE_W(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd), .go_addr(go_addr),
    .go_wdata(go_wdata), .ee_req(ee_req), .ee_rd_nwr(ee_rd_nwr),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ready(ee_ready), .fin(fin)
  );

  eld_ctrl #(.EE_AW(EE_AW), .BYTE_W(BYTE_W), .BASE_W(BASE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rq_rd(rq_rd), .rq_wr(rq_wr), .burst_q(burst_q),
    .addr_q(addr_q), .data_q(data_q), .base_q(base_q), .fin(fin),
    .fin_data(ee_rdata), .cur_rd(ee_rd_nwr), .port_req(ee_req), .go(go),
    .go_rd(go_rd), .go_addr(go_addr), .go_wdata(go_wdata),
    .clr_single(clr_single), .load_data(load_data), .clr_burst(clr_burst),
    .fsm_active(fsm_active), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  AST_BURST_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_q) |-> !fsm_active) else $error("load bit cleared mid-burst"); // R5
endmodule

// File: tb/test_eeprom_loader.sv
module test_eeprom_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ee_req, ee_rd_nwr;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata;
  logic        ee_ready = 1'b0;
  logic [7:0]  ee_rdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;

  eeprom_loader i_eeprom_loader (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ee_req(ee_req),
    .ee_rd_nwr(ee_rd_nwr), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_ready(ee_ready), .ee_rdata(ee_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // EEPROM model: two-cycle latency, one ready pulse per request
  logic [7:0]  eemem [0:1023];
  int          ecnt = 0;
  int          xacts = 0;
  logic [15:0] last_ee = '0;
  // memory sink with optional stall
  logic [23:0] rec_addr [0:15];
  logic [7:0]  rec_data [0:15];
  int          rec_n = 0;
  int          phase = 0;
  bit          stall_en = 1'b0;

  always @(negedge clk) begin
    if (ee_ready) begin
      if (!ee_rd_nwr) eemem[ee_addr[9:0]] = ee_wdata;
      last_ee = ee_addr;
      xacts++;
      ee_ready = 1'b0;
      ecnt = 0;
    end else if (ee_req) begin
      ecnt++;
      if (ecnt >= 2) begin
        ee_ready = 1'b1;
        ee_rdata = eemem[ee_addr[9:0]];
      end
    end
    phase++;
    mem_ready = !stall_en || (phase % 3 == 2);
    if (mem_valid && mem_ready && rec_n < 16) begin
      rec_addr[rec_n] = mem_addr;
      rec_data[rec_n] = mem_data;
      rec_n++;
    end
  end

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  localparam logic [24:0] VEC [0:7] = '{
    {1'b1, 16'h0100, 8'h5A},
    {1'b0, 16'h0100, 8'h5A},
    {1'b1, 16'h0200, 8'hC3},
    {1'b0, 16'h0200, 8'hC3},
    {1'b0, 16'h0003, 8'hA1},
    {1'b1, 16'h0040, 8'h77},
    {1'b0, 16'h0101, 8'h00},
    {1'b0, 16'h0040, 8'h77}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    host_sel = sel; host_wdata = val; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] sel, output logic [31:0] val);
    host_sel = sel;
    #1;
    val = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      hread(3'd0, v);
      if (!v[2]) break;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int x0, r0;
    for (int i = 0; i < 1024; i++) eemem[i] = 8'h00;
    // image 1 at address 0
    eemem[0] = 8'h81; eemem[1] = 8'h23; eemem[2] = 8'h02; eemem[3] = 8'hA1;
    eemem[4] = 8'hA2; eemem[5] = 8'h7F; eemem[6] = 8'hFF; eemem[7] = 8'h02;
    eemem[8] = 8'hB1; eemem[9] = 8'hB2;
    // image 2 at 0x41
    eemem[10'h41] = 8'h00; eemem[10'h42] = 8'h05; eemem[10'h43] = 8'h01;
    eemem[10'h44] = 8'hEE;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    for (int s = 0; s < 5; s++) begin
      hread(3'(s), v);
      check("R12 reg reset", v, 32'h0);
    end
    check("R12 ee_req idle", {31'h0, ee_req}, 32'h0);
    check("R12 mem_valid idle", {31'h0, mem_valid}, 32'h0);

    // first burst after reset, stalled sink
    stall_en = 1'b1;
    hwrite(3'd3, 32'h1A5);
    x0 = xacts;
    hwrite(3'd4, 32'h1);
    hread(3'd0, v);
    check("R4 busy during burst", {31'h0, v[2]}, 32'h1);
    wait_idle();
    hread(3'd4, v);
    check("R5 load bit cleared", v, 32'h0);
    check("R6 burst reads from 0", 32'(xacts - x0), 32'd13);
    check("R8 byte count", 32'(rec_n), 32'd4);
    check("R9 first addr (msb dropped)", {8'h0, rec_addr[0]}, 32'hD28123);
    check("R11 first data", {24'h0, rec_data[0]}, 32'hA1);
    check("R9 increment", {8'h0, rec_addr[1]}, 32'hD28124);
    check("R11 second data", {24'h0, rec_data[1]}, 32'hA2);
    check("R9 before wrap", {8'h0, rec_addr[2]}, 32'hD2FFFF);
    check("R9 wrap in 15 bits", {8'h0, rec_addr[3]}, 32'hD28000);
    check("R11 wrapped data", {24'h0, rec_data[3]}, 32'hB2);
    stall_en = 1'b0;

    // table of single accesses
    for (int k = 0; k < 8; k++) begin
      hwrite(3'd1, {16'h0, VEC[k][23:8]});
      if (VEC[k][24]) begin
        hwrite(3'd2, {24'h0, VEC[k][7:0]});
        hwrite(3'd0, 32'h1);
        wait_idle();
        hread(3'd0, v);
        check("R2 write bit clears", v, 32'h0);
        check("R2 byte stored", {24'h0, eemem[VEC[k][17:8]]}, {24'h0, VEC[k][7:0]});
      end else begin
        hwrite(3'd0, 32'h2);
        wait_idle();
        hread(3'd0, v);
        check("R1 read bit clears", v, 32'h0);
        hread(3'd2, v);
        check("R1 read data", v, {24'h0, VEC[k][7:0]});
      end
    end

    // second burst resumes after 0x40; host writes while busy are dropped
    hwrite(3'd3, 32'h003);
    x0 = xacts; r0 = rec_n;
    hwrite(3'd4, 32'h1);
    hwrite(3'd1, 32'h1234);
    hwrite(3'd0, 32'h2);
    wait_idle();
    check("R7 resume reads", 32'(xacts - x0), 32'd7);
    check("R7 one byte written", 32'(rec_n - r0), 32'd1);
    check("R9 new base addr", {8'h0, rec_addr[r0]}, 32'h018005);
    check("R11 data", {24'h0, rec_data[r0]}, 32'hEE);
    hread(3'd1, v);
    check("R4 addr write ignored", v, 32'h0040);
    hread(3'd0, v);
    check("R4 cmd write ignored", v, 32'h0);

    // both request bits
    hwrite(3'd1, 32'h0100);
    hwrite(3'd2, 32'h11);
    x0 = xacts;
    hwrite(3'd0, 32'h3);
    wait_idle();
    hread(3'd2, v);
    check("R3 read wins", v, 32'h5A);
    check("R3 no write", {24'h0, eemem[10'h100]}, 32'h5A);
    check("R10 one transfer", 32'(xacts - x0), 32'd1);
    hread(3'd0, v);
    check("R3 both bits clear", v, 32'h0);

    // empty burst after a single access: resumes at 0x101
    x0 = xacts; r0 = rec_n;
    hwrite(3'd4, 32'h1);
    wait_idle();
    check("R8 zero count ends", 32'(xacts - x0), 32'd3);
    check("R7 last read addr", {16'h0, last_ee}, 32'h0103);
    check("R8 no memory write", 32'(rec_n - r0), 32'd0);
    hread(3'd4, v);
    check("R5 load bit cleared again", v, 32'h0);

    finish_run();
  end
endmodule